// File: doc/BRIEF.md
# Sequential 32-by-16 Divider with Divide-Error Faults

This block divides a 32-bit dividend by a 16-bit divisor, one quotient bit per clock. The dividend is built from two 16-bit input words, the upper word forming bits 31..16 and the lower word bits 15..0. A mode input selects between unsigned and two's-complement signed division. The block returns a 16-bit quotient and a 16-bit remainder. A CPU-style execution unit would use it to carry out a double-width divide instruction.

The block checks for three conditions that make the result unusable: a zero divisor, a quotient that does not fit in 16 bits, and, in signed mode, the most negative 32-bit dividend. In any of these cases it reports a divide-error fault instead of writing a result. The zero-divisor and most-negative-dividend faults are found from the operands alone, so they are reported one cycle after start. All other operations run the full shift-subtract sequence. The quotient check is done after the signs have been corrected.

Top module: `word_divider`

## Requirements
- R1: The dividend is `{dvd_hi, dvd_lo}`. In unsigned mode (`signed_mode`=0), a successful operation sets `quotient` to floor(dividend/divisor) and `remainder` to dividend mod divisor.
- R2: A divisor of zero gives `done`=1 and `div_fault`=1 in the cycle after the edge that samples `start`. This holds in both modes.
- R3: In unsigned mode, a quotient of 65536 or more raises `div_fault`. A quotient of exactly 65535 is a valid result.
- R4: In signed mode, a dividend of 32'h80000000 raises `div_fault` together with `done` in the cycle after the edge that samples `start`. This happens whatever the divisor is.
- R5: In signed mode, a quotient outside -32768..32767 raises `div_fault`. Both ends of that range are valid results.
- R6: Signed division rounds toward zero. The remainder has the sign of the dividend, or is zero, and is smaller in magnitude than the divisor.
- R7: When `div_fault` is high, `quotient` and `remainder` keep the values they had before. `div_fault` is high only in a cycle where `done` is high.
- R8: An operation without an early fault raises `done` after the 34th rising edge, counting the edge that samples `start` as the first. `done` lasts one cycle.
- R9: A `start` pulse that arrives while an operation is in progress is ignored. The result that comes out belongs to the first operation, with its normal latency.
- R10: After reset, `quotient`=0, `remainder`=0, `done`=0 and `div_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the block is idle |
| dvd_hi | input | 16 | Upper word of the dividend |
| dvd_lo | input | 16 | Lower word of the dividend |
| divisor | input | 16 | Divisor |
| signed_mode | input | 1 | 1 = two's-complement signed, 0 = unsigned |
| quotient | output | 16 | Quotient of the last successful operation |
| remainder | output | 16 | Remainder of the last successful operation |
| div_fault | output | 1 | Divide-error fault, high with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
Unsigned operands are chosen below, at and above the 65535 quotient limit, so the checks separate a correct high-half test from an off-by-one test. Signed operands cover all four sign combinations, which separates rounding toward zero from floor rounding and shows which operand the remainder's sign follows. Quotients of exactly -32768 and +32768 show whether the range check is asymmetric, and a divisor of -32768 exercises the magnitude path. Zero divisors and the most negative dividend are tried in both modes, which shows that the fast fault path applies only in signed mode. A fault placed directly after a known good result, and a second start sent during a running operation, show whether the outputs are held correctly.

// File: rtl/word_divider.sv
module word_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  input  logic         signed_mode,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_fault,
  output logic         done
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [W-1:0]  dmag, rem_q;
  logic [DW-1:0] quo_q;
  logic          neg_q, neg_r, sgn_q;

  wire [DW-1:0] dvd    = {dvd_hi, dvd_lo};
  wire          a_neg  = signed_mode & dvd[DW-1];
  wire          b_neg  = signed_mode & divisor[W-1];
  wire [DW-1:0] a_mag  = a_neg ? -dvd : dvd;
  wire [W-1:0]  b_mag  = b_neg ? -divisor : divisor;
  wire          min_in = signed_mode && (dvd == {1'b1, {(DW-1){1'b0}}});
  wire          early  = (divisor == '0) || min_in;

  wire [W:0]    shifted = {rem_q, quo_q[DW-1]};
  wire          ge      = shifted >= {1'b0, dmag};
  wire [W:0]    diff    = shifted - {1'b0, dmag};

  wire [DW-1:0] q_sgn = neg_q ? -quo_q : quo_q;
  wire [W-1:0]  r_sgn = neg_r ? -rem_q : rem_q;
  wire          ovf   = sgn_q ? (q_sgn[DW-1:W] != {W{q_sgn[W-1]}})
                              : (quo_q[DW-1:W] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      dmag      <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      neg_q     <= 1'b0;
      neg_r     <= 1'b0;
      sgn_q     <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      done      <= 1'b0;
      div_fault <= 1'b0;
    end else begin
      done      <= 1'b0;
      div_fault <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (early) begin
            done      <= 1'b1;
            div_fault <= 1'b1;
          end else begin
            st    <= RUN;
            cnt   <= '0;
            dmag  <= b_mag;
            rem_q <= '0;
            quo_q <= a_mag;
            neg_q <= a_neg ^ b_neg;
            neg_r <= a_neg;
            sgn_q <= signed_mode;
          end
        end
        RUN: begin
          rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
          quo_q <= {quo_q[DW-2:0], ge};
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(DW - 1)) st <= FIN;
        end
        FIN: begin
          st        <= IDLE;
          done      <= 1'b1;
          div_fault <= ovf;
          if (!ovf) begin
            quotient  <= q_sgn[W-1:0];
            remainder <= r_sgn;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R2
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && start && divisor == '0) |=> (done && div_fault));

  // R4
  min_dvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && start && min_in) |=> (done && div_fault));

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_fault |-> (done && $stable(quotient) && $stable(remainder)));

  // R6
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_fault) |-> (rem_q < dmag));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN) |-> !done);

  // R8
  fin_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FIN) |=> (done && st == IDLE));
endmodule

// File: tb/word_divider_bench.sv
module word_divider_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic signed_mode = 1'b0;
  logic [15:0] quotient, remainder;
  logic div_fault, done;

  int checks = 0, errors = 0;
  logic [15:0] last_q = '0, last_r = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  word_divider u_word_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo),
    .divisor(divisor), .signed_mode(signed_mode), .quotient(quotient),
    .remainder(remainder), .div_fault(div_fault), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ref_div(input logic [15:0] hi, lo, dv, input logic sg,
                         output bit flt, output logic [15:0] q, r, output int lat);
    logic [31:0] d;
    longint a, b, qq, rr;
    d = {hi, lo};
    q = last_q; r = last_r;
    if (dv == 0 || (sg && d == 32'h8000_0000)) begin
      flt = 1; lat = 1;
      return;
    end
    lat = 34;
    if (sg) begin a = longint'(signed'(d)); b = longint'(signed'(dv)); end
    else begin a = longint'({32'b0, d}); b = longint'({48'b0, dv}); end
    qq = a / b; rr = a % b;
    flt = sg ? (qq > 32767 || qq < -32768) : (qq > 65535);
    if (!flt) begin q = qq[15:0]; r = rr[15:0]; end
  endtask

  task automatic run_div(input string req, input logic [15:0] hi, lo, dv, input logic sg,
                         input bit poke_busy);
    bit eflt; logic [15:0] eq, er; int elat, lat;
    ref_div(hi, lo, dv, sg, eflt, eq, er, elat);
    @(negedge clk);
    dvd_hi = hi; dvd_lo = lo; divisor = dv; signed_mode = sg; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      if (poke_busy && lat == 5) begin
        dvd_hi = 16'h0; dvd_lo = 16'h0; divisor = 16'h0; start = 1'b1;
      end else start = 1'b0;
      @(posedge clk); lat++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(req, "latency", lat, elat);
    chk(req, "fault", div_fault, eflt);
    chk(req, "quotient", quotient, eq);
    chk(req, "remainder", remainder, er);
    last_q = eq; last_r = er;
    @(negedge clk);
    chk("R8", "done pulse width", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset quotient", quotient, 0);
    chk("R10", "reset remainder", remainder, 0);
    chk("R10", "reset done", done, 0);
    chk("R10", "reset fault", div_fault, 0);
    rst_n = 1'b1;
    // R1 unsigned
    run_div("R1", 16'h0001, 16'h2345, 16'h0007, 0, 0);
    run_div("R1", 16'h1234, 16'h5678, 16'hABCD, 0, 0);
    run_div("R3", 16'h0000, 16'hFFFF, 16'h0001, 0, 0);
    run_div("R3", 16'hFFFE, 16'hFFFF, 16'hFFFF, 0, 0);
    run_div("R3", 16'h0001, 16'h0000, 16'h0001, 0, 0);
    run_div("R3", 16'hFFFF, 16'h0000, 16'hFFFF, 0, 0);
    // R7 fault after a known result keeps it
    run_div("R1", 16'h0000, 16'h0064, 16'h0009, 0, 0);
    run_div("R7", 16'h0000, 16'h0064, 16'h0000, 0, 0);
    run_div("R2", 16'h1234, 16'h0000, 16'h0000, 1, 0);
    // R4 in signed mode; unsigned takes the long path
    run_div("R4", 16'h8000, 16'h0000, 16'h0001, 1, 0);
    run_div("R4", 16'h8000, 16'h0000, 16'hFFFF, 1, 0);
    run_div("R3", 16'h8000, 16'h0000, 16'h8000, 0, 0);
    // R6 sign combinations
    run_div("R6", 16'hFFFF, 16'hFFF9, 16'h0002, 1, 0);
    run_div("R6", 16'h0000, 16'h0007, 16'hFFFE, 1, 0);
    run_div("R6", 16'hFFFF, 16'hFF9C, 16'hFFF9, 1, 0);
    run_div("R6", 16'h0012, 16'h3456, 16'h0789, 1, 0);
    run_div("R6", 16'hFFFF, 16'h0000, 16'h8000, 1, 0);
    // R5 boundaries
    run_div("R5", 16'hFFFF, 16'h8000, 16'h0001, 1, 0);
    run_div("R5", 16'h0000, 16'h7FFF, 16'h0001, 1, 0);
    run_div("R5", 16'h0000, 16'h8000, 16'h0001, 1, 0);
    run_div("R5", 16'h0000, 16'h8000, 16'hFFFF, 1, 0);
    run_div("R5", 16'h7FFF, 16'hFFFF, 16'h7FFF, 1, 0);
    // R9 busy start ignored
    run_div("R9", 16'h0003, 16'h0000, 16'h0010, 0, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule